// File: doc/BRIEF.md
# Fall-Through Word Chain FIFO

This block is a first-in first-out buffer of 64 words, each 5 bits wide. It has no RAM and no read or write pointers. The storage is a series of word positions: one entry position, 62 middle positions and one exit position. Each position has a data register and an occupied bit. Any occupied position whose downstream neighbour is empty hands its word forward on the next clock. A word written at the entry therefore falls through the empty positions until it reaches the exit, or until it stops behind the words already queued there.

Writing and reading are independent. A rising edge on the shift-in strobe captures the input word. A falling edge on the active-low shift-out strobe releases the word held at the exit. Two flags report the state of the ends: in_rdy means the entry position is free, and out_rdy means the exit position holds a valid word. An active-low master reset empties every position at once, without waiting for a clock. An active-low output enable either drives the exit word onto the data outputs or releases them to high impedance. Everything except the reset is timed by a single system clock. Both strobes are sampled on that clock and edge-detected.

Top module: `fifo_chain`

## Requirements
- R1: rst_n low clears every occupied bit at once, with no clock edge needed; while it is low, in_rdy reads 1 and out_rdy reads 0.
- R2: a word on din is captured on the first clock edge after shift_in rises, provided in_rdy is 1 at that edge; holding shift_in high captures nothing more.
- R3: a rising edge of shift_in while in_rdy is 0 (device full) is ignored, and that word never appears at the output.
- R4: a falling edge of shift_out_n while out_rdy is 1 removes the exit word, and out_rdy stays 1 until such a read occurs.
- R5: a falling edge of shift_out_n while out_rdy is 0 is ignored and removes nothing.
- R6: words leave in exactly the order in which they were accepted.
- R7: capacity is 64 words; once 64 words are held and have settled, in_rdy is 0.
- R8: a word moves at most one position per clock; on an empty device, out_rdy rises on the 64th clock edge, counting the edge that captured the word.
- R9: with oe_n low, dout shows the word at the exit position; with oe_n high, dout is released to high impedance.
- R10: a read and a write strobed on the same clock edge are both carried out, each judged only by its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous master reset, active low |
| shift_in | input | 1 | write strobe, active high, rising-edge detected |
| shift_out_n | input | 1 | read strobe, active low, falling-edge detected |
| oe_n | input | 1 | output enable, active low |
| din | input | 5 | word to be written |
| dout | output | 5 | exit word, or high impedance when oe_n is high |
| in_rdy | output | 1 | entry position is free |
| out_rdy | output | 1 | exit position holds a valid word |

## Verification
A write at the entry and a read at the exit can occur on the same clock edge. Each then changes a different end of the chain, while words in the middle keep advancing. The bench provokes this by asserting both strobes at the same clock edge, many times in a row, on a device that is partly filled. For each strobe it first samples that strobe's own flag, so the scoreboard queue accepts the write and pops the read independently. Every popped word must match the oldest queued word, and at the end the device must be drained with an empty queue.

// File: rtl/fifo_chain.sv
module fifo_chain #(
  parameter int W     = 5,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_in,
  input  logic         shift_out_n,
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         in_rdy,
  output logic         out_rdy
);

  logic si_q, so_q;
  logic wr_stb, rd_stb;
  logic [DEPTH-1:0]        occ, up_v, dn_v, take, give;
  logic [DEPTH-1:0][W-1:0] word, src;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      si_q <= 1'b1;
      so_q <= 1'b0;
    end else begin
      si_q <= shift_in;
      so_q <= shift_out_n;
    end

  assign wr_stb = shift_in & ~si_q;
  assign rd_stb = so_q & ~shift_out_n;

  assign up_v = {occ[DEPTH-2:0], wr_stb};
  assign dn_v = {rd_stb, ~occ[DEPTH-1:1]};
  assign src  = {word[DEPTH-2:0], din};
  assign take = up_v & ~occ;
  assign give = occ & dn_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) occ <= '0;
    else        occ <= (occ & ~give) | take;

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++)
      if (take[i]) word[i] <= src[i];

  assign in_rdy  = ~occ[0];
  assign out_rdy = occ[DEPTH-1];
  assign dout    = oe_n ? {W{1'bz}} : word[DEPTH-1];

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int W     = 5,
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [DEPTH-1:0] occ,
  input logic             in_rdy,
  input logic             out_rdy
);

  // R2
  in_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rdy) |-> $past(wr_stb));

  // R5
  out_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_rdy) |-> $past(rd_stb));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && !rd_stb) |=> out_rdy);

  // R3
  no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $countones(occ) <= $past($countones(occ)));

  // R6
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $countones(occ) >= $past($countones(occ)));

endmodule

bind fifo_chain fifo_chain_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .occ(occ), .in_rdy(in_rdy), .out_rdy(out_rdy)
);

// File: tb/fifo_chain_tb.sv
module fifo_chain_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, shift_in = 1'b0, shift_out_n = 1'b1, oe_n = 1'b0;
  logic [4:0] din = '0;
  logic [4:0] dout;
  logic in_rdy, out_rdy;

  int vectors = 0, miscompares = 0, pops = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  logic [4:0] samp;
  string tag = "R6";
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_chain dut_i (.clk(clk), .rst_n(rst_n), .shift_in(shift_in),
    .shift_out_n(shift_out_n), .oe_n(oe_n), .din(din), .dout(dout),
    .in_rdy(in_rdy), .out_rdy(out_rdy));

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(rd_ev) begin
    if (exp_q.size() == 0) chk(0, {tag, " read from empty model"}, samp, 0);
    else begin
      logic [4:0] e;
      e = exp_q.pop_front();
      pops++;
      chk(samp === e, tag, samp, e);
    end
  end

  task automatic wr(input logic [4:0] d);
    @(negedge clk);
    din = d;
    if (in_rdy) exp_q.push_back(d);
    shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  task automatic wr_wait(input logic [4:0] d);
    for (int n = 0; n < 300 && !in_rdy; n++) @(negedge clk);
    wr(d);
  endtask

  task automatic rd();
    @(negedge clk);
    if (out_rdy) begin samp = dout; ->rd_ev; end
    shift_out_n = 1'b0;
    @(negedge clk);
    shift_out_n = 1'b1;
  endtask

  task automatic rd_wait();
    for (int n = 0; n < 300 && !out_rdy; n++) @(negedge clk);
    rd();
  endtask

  task automatic both(input logic [4:0] d);
    @(negedge clk);
    din = d;
    if (out_rdy) begin samp = dout; ->rd_ev; end
    if (in_rdy) exp_q.push_back(d);
    shift_in = 1'b1;
    shift_out_n = 1'b0;
    @(negedge clk);
    shift_in = 1'b0;
    shift_out_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    idle(3);
    chk(in_rdy === 1'b1, "R1 in_rdy in reset", in_rdy, 1);
    chk(out_rdy === 1'b0, "R1 out_rdy in reset", out_rdy, 0);
    rst_n = 1'b1;
    idle(2);

    // R8 fall-through latency
    @(negedge clk);
    din = 5'h15;
    exp_q.push_back(5'h15);
    shift_in = 1'b1;
    n = 0;
    while (!out_rdy && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1) shift_in = 1'b0;
    end
    chk(n == 64, "R8 edges to out_rdy", n, 64);
    // R9 output enable
    chk(dout === 5'h15, "R9 dout enabled", dout, 5'h15);
    oe_n = 1'b1;
    #1;
    chk(dout !== 5'h15, "R9 dout released", dout, 0);
    oe_n = 1'b0;
    #1;
    tag = "R4";
    rd();
    idle(3);
    chk(out_rdy === 1'b0, "R4 out_rdy after last read", out_rdy, 0);

    // R5 empty read
    rd();
    idle(5);
    chk(out_rdy === 1'b0 && in_rdy === 1'b1, "R5 empty read flags", {out_rdy, in_rdy}, 2'b01);

    // R2 held strobe captures once
    @(negedge clk);
    din = 5'h07;
    if (in_rdy) exp_q.push_back(5'h07);
    shift_in = 1'b1;
    idle(8);
    shift_in = 1'b0;
    tag = "R2";
    rd_wait();
    idle(100);
    chk(out_rdy === 1'b0, "R2 single capture", out_rdy, 0);

    // R7 fill to capacity
    for (int i = 0; i < 64; i++) wr_wait(5'(i) ^ 5'h0a);
    idle(150);
    chk(in_rdy === 1'b0, "R7 full after 64", in_rdy, 0);
    chk(out_rdy === 1'b1, "R7 out_rdy when full", out_rdy, 1);
    chk(exp_q.size() == 64, "R7 words accepted", exp_q.size(), 64);
    // R3 write while full
    wr(5'h1f);
    idle(3);
    chk(in_rdy === 1'b0, "R3 still full", in_rdy, 0);
    tag = "R6";
    for (int i = 0; i < 64; i++) rd_wait();
    idle(100);
    chk(out_rdy === 1'b0, "R3 extra word absent", out_rdy, 0);
    chk(exp_q.size() == 0, "R6 model drained", exp_q.size(), 0);
    rd();
    idle(3);

    // R10 simultaneous read and write
    for (int i = 0; i < 10; i++) wr_wait(5'(i + 3));
    idle(120);
    tag = "R10";
    for (int i = 0; i < 20; i++) begin
      both(5'(i * 7 + 1));
      idle(i % 3);
    end
    for (int k = 0; k < 200 && exp_q.size() > 0; k++) rd_wait();
    idle(100);
    chk(exp_q.size() == 0 && out_rdy === 1'b0, "R10 drained after mixed", exp_q.size(), 0);
    chk(pops == 1 + 1 + 64 + 30, "R10 total words out", pops, 96);

    // R1 asynchronous reset mid-cycle
    for (int i = 0; i < 5; i++) wr_wait(5'(i + 20));
    idle(80);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk(out_rdy === 1'b0, "R1 async out_rdy", out_rdy, 0);
    chk(in_rdy === 1'b1, "R1 async in_rdy", in_rdy, 1);
    exp_q.delete();
    idle(2);
    rst_n = 1'b1;
    idle(2);
    tag = "R1";
    wr(5'h0c);
    rd_wait();
    idle(80);
    chk(out_rdy === 1'b0, "R1 empty after reset", out_rdy, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule